// File: doc/BRIEF.md
# Partitioned Flash Read-While-Program Arbiter

This block sits beside the command decoder of a flash array that is split into independent partitions. It keeps a read mode for every partition and follows one buffered program from its setup command, through confirmation and the busy period, to completion or abort. For every read request it names the source that must drive the data bus: the array, the status register, the identifier space, the query space, or nothing at all. It also drives the ready and command-sequence-error bits of the status register, and it gives a one-cycle abort pulse when a read-array command cuts a program short.

A read to the partition that owns the program always returns status. Another partition that was already in array mode may serve array data while the program runs. First, a read must load a new block address into that partition. After that, later reads of the same block are served without a reload. If a read-array command goes to a partition that is in some other mode, the program stops and a sequence error is posted. The fast factory program variant allows no read from any other partition while it runs.

Commands arrive already decoded: a code and a partition number, valid for one cycle. A read presents a block address whose top bits select the partition, plus a flag that marks the address as newly issued.

Top module: `rwp_arbiter`

## Requirements
- R1: After reset every partition is in array mode. A read of any partition returns source 0 (array), `sr_ready` is 1, `sr_seq_err` is 0 and `prog_abort` is 0.
- R2: Outside a program, a command sets the mode of the addressed partition. 8'hFF selects array (source 0), 8'h70 selects status (source 1), 8'h90 selects identifier (source 2) and 8'h98 selects query (source 3). A read returns the source of the partition in the top PART_W bits of `rd_blk`. With `rd_valid` low, `rd_src` is 4.
- R3: A setup command (8'hE8 for buffered, 8'h80 for fast factory) to partition P moves only P into the program state. From the next cycle, reads of P return source 1 whatever P's mode was before. Other partitions keep their modes.
- R4: 8'hD0 sent to P after setup starts the busy period. `sr_ready` is 0 for exactly PROG_BUSY_CYCLES cycles, starting the cycle after the confirm. Afterwards P keeps returning source 1 until 8'hFF is sent to P.
- R5: During a buffered program, a read of another partition that is in array mode returns source 4 unless one of two conditions holds. The read itself carries `rd_new_blk`, or it hits the block that partition last latched with `rd_new_blk` since the setup. In either case it returns source 0.
- R6: During a program, 8'hFF to another partition that is not in array mode does four things. It pulses `prog_abort` for one cycle, sets `sr_seq_err`, ends the program (`sr_ready` is 1) and puts that partition in array mode.
- R7: During a program, 8'hFF to another partition that is already in array mode causes no abort, and the program goes on.
- R8: `sr_seq_err` stays set through every command except 8'h50, which clears it.
- R9: During a fast factory program, every read of a partition other than P returns source 4, even with `rd_new_blk`.
- R10: While a program is active, commands to P other than the confirm are ignored, and setup commands to any partition are ignored.
- R11: During a buffered program, 8'h70, 8'h90 and 8'h98 to another partition change its mode as in R2, and its reads return that source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Decoded command present this cycle |
| cmd_code | input | 8 | Command code |
| cmd_part | input | PART_W | Partition the command addresses |
| rd_valid | input | 1 | Read request present |
| rd_blk | input | BLK_W | Block address of the read; top PART_W bits select the partition |
| rd_new_blk | input | 1 | The read issues a new block address |
| rd_src | output | 3 | Data source: 0 array, 1 status, 2 identifier, 3 query, 4 none |
| prog_abort | output | 1 | One-cycle pulse when a program is aborted |
| sr_ready | output | 1 | Status register ready bit |
| sr_seq_err | output | 1 | Status register command-sequence error bit |

## Verification
A wrong mode bit shows on the next read of that partition, because `rd_src` is combinational from the stored state. The sweep reads every partition after every mode command, so the error shows within one read. A program-owner register or phase that points to the wrong partition or the wrong state shows in one of two ways: a read of the owner does not return status, or `sr_ready` toggles at the wrong moment. The busy window is counted cycle by cycle. A stale latched block or a stuck fresh flag shows when another block of the same partition is read during a program without a new address, which is the first such read.

// File: rtl/rwp_arbiter.sv
module rwp_arbiter #(
  parameter int NUM_PARTS        = 8,
  parameter int BLK_W            = 10,
  parameter int PROG_BUSY_CYCLES = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_valid,
  input  logic [7:0]                   cmd_code,
  input  logic [$clog2(NUM_PARTS)-1:0] cmd_part,
  input  logic                         rd_valid,
  input  logic [BLK_W-1:0]             rd_blk,
  input  logic                         rd_new_blk,
  output logic [2:0]                   rd_src,
  output logic                         prog_abort,
  output logic                         sr_ready,
  output logic                         sr_seq_err
);
  localparam int PART_W = $clog2(NUM_PARTS);
  localparam int LOC_W  = BLK_W - PART_W;
  localparam int CNT_W  = $clog2(PROG_BUSY_CYCLES + 1);

  localparam logic [7:0] OP_RD_ARRAY  = 8'hFF;
  localparam logic [7:0] OP_RD_STATUS = 8'h70;
  localparam logic [7:0] OP_RD_ID     = 8'h90;
  localparam logic [7:0] OP_RD_QUERY  = 8'h98;
  localparam logic [7:0] OP_CLR_SR    = 8'h50;
  localparam logic [7:0] OP_BUF_PROG  = 8'hE8;
  localparam logic [7:0] OP_FAST_PROG = 8'h80;
  localparam logic [7:0] OP_CONFIRM   = 8'hD0;

  localparam logic [1:0] M_ARRAY  = 2'd0;
  localparam logic [1:0] M_STATUS = 2'd1;
  localparam logic [1:0] M_ID     = 2'd2;
  localparam logic [1:0] M_QUERY  = 2'd3;

  localparam logic [1:0] PH_IDLE  = 2'd0;
  localparam logic [1:0] PH_SETUP = 2'd1;
  localparam logic [1:0] PH_BUSY  = 2'd2;

  localparam logic [2:0] SRC_NONE = 3'd4;

  logic [1:0]        mode     [NUM_PARTS];
  logic [LOC_W-1:0]  last_loc [NUM_PARTS];
  logic [NUM_PARTS-1:0] fresh;
  logic [1:0]        phase;
  logic [PART_W-1:0] prog_part;
  logic              fast;
  logic [CNT_W-1:0]  busy_cnt;

  wire [PART_W-1:0] rd_part = rd_blk[BLK_W-1 -: PART_W];
  wire [LOC_W-1:0]  rd_loc  = rd_blk[LOC_W-1:0];
  wire active     = phase != PH_IDLE;
  wire is_setup   = cmd_code == OP_BUF_PROG || cmd_code == OP_FAST_PROG;
  wire setup_go   = cmd_valid && !active && is_setup;
  wire cmd_own    = active && cmd_part == prog_part;
  wire abort_now  = cmd_valid && active && !cmd_own &&
                    cmd_code == OP_RD_ARRAY && mode[cmd_part] != M_ARRAY;
  wire done_now   = phase == PH_BUSY && busy_cnt == CNT_W'(PROG_BUSY_CYCLES - 1);

  for (genvar p = 0; p < NUM_PARTS; p++) begin : g_part
    wire hit    = cmd_valid && cmd_part == PART_W'(p) && !(active && prog_part == PART_W'(p));
    wire rd_hit = rd_valid && rd_new_blk && rd_part == PART_W'(p);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode[p] <= M_ARRAY;
      end else if (hit) begin
        case (cmd_code)
          OP_RD_ARRAY:  mode[p] <= M_ARRAY;
          OP_RD_STATUS: mode[p] <= M_STATUS;
          OP_RD_ID:     mode[p] <= M_ID;
          OP_RD_QUERY:  mode[p] <= M_QUERY;
          OP_BUF_PROG, OP_FAST_PROG: if (!active) mode[p] <= M_STATUS;
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fresh[p]    <= 1'b0;
        last_loc[p] <= '0;
      end else if (setup_go) begin
        fresh[p]    <= 1'b0;
      end else if (rd_hit) begin
        fresh[p]    <= 1'b1;
        last_loc[p] <= rd_loc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      prog_part  <= '0;
      fast       <= 1'b0;
      busy_cnt   <= '0;
      prog_abort <= 1'b0;
      sr_seq_err <= 1'b0;
    end else begin
      prog_abort <= abort_now;
      if (abort_now)
        sr_seq_err <= 1'b1;
      else if (cmd_valid && cmd_code == OP_CLR_SR)
        sr_seq_err <= 1'b0;

      if (abort_now) begin
        phase <= PH_IDLE;
      end else begin
        case (phase)
          PH_IDLE: if (setup_go) begin
            phase     <= PH_SETUP;
            prog_part <= cmd_part;
            fast      <= cmd_code == OP_FAST_PROG;
          end
          PH_SETUP: if (cmd_valid && cmd_own && cmd_code == OP_CONFIRM) begin
            phase    <= PH_BUSY;
            busy_cnt <= '0;
          end
          PH_BUSY: begin
            if (done_now) phase <= PH_IDLE;
            else          busy_cnt <= busy_cnt + 1'b1;
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  assign sr_ready = phase != PH_BUSY;

  wire array_ok = !active || rd_new_blk ||
                  (fresh[rd_part] && last_loc[rd_part] == rd_loc);

  always_comb begin
    if (!rd_valid)
      rd_src = SRC_NONE;
    else if (active && rd_part == prog_part)
      rd_src = {1'b0, M_STATUS};
    else if (active && fast)
      rd_src = SRC_NONE;
    else if (mode[rd_part] == M_ARRAY)
      rd_src = array_ok ? {1'b0, M_ARRAY} : SRC_NONE;
    else
      rd_src = {1'b0, mode[rd_part]};
  end
endmodule

module rwp_arbiter_chk #(
  parameter int PART_W = 3,
  parameter int BLK_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [7:0]        cmd_code,
  input logic              rd_valid,
  input logic [BLK_W-1:0]  rd_blk,
  input logic [2:0]        rd_src,
  input logic              prog_abort,
  input logic              sr_ready,
  input logic              sr_seq_err,
  input logic [1:0]        phase,
  input logic [PART_W-1:0] prog_part,
  input logic              fast
);
  wire [PART_W-1:0] rpart = rd_blk[BLK_W-1 -: PART_W];

  AST_OWNER_READS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && phase != 2'd0 && rpart == prog_part |-> rd_src == 3'd1); // R3
  AST_FAST_BLOCKS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && phase != 2'd0 && fast && rpart != prog_part |-> rd_src == 3'd4); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sr_seq_err && !(cmd_valid && cmd_code == 8'h50) |=> sr_seq_err); // R8
  AST_ABORT_POSTS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    prog_abort |-> sr_seq_err && sr_ready); // R6
  AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    prog_abort |=> !prog_abort); // R6
  AST_OWNER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd0 |=> $stable(prog_part)); // R10
  AST_BUSY_AFTER_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_ready) |-> $past(cmd_valid) && $past(cmd_code) == 8'hD0); // R4
  AST_SRC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_src <= 3'd4); // R2
  AST_IDLE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> rd_src == 3'd4); // R2
endmodule

bind rwp_arbiter rwp_arbiter_chk #(.PART_W(PART_W), .BLK_W(BLK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .rd_valid(rd_valid), .rd_blk(rd_blk), .rd_src(rd_src),
  .prog_abort(prog_abort), .sr_ready(sr_ready), .sr_seq_err(sr_seq_err),
  .phase(phase), .prog_part(prog_part), .fast(fast)
);

// File: tb/tb_rwp_arbiter.sv
module tb_rwp_arbiter;
  localparam int NP = 4;
  localparam int PW = 2;
  localparam int BW = 6;
  localparam int PROG = 6;

  logic clk = 0;
  logic rst_n = 0;
  logic cmd_valid = 0;
  logic [7:0] cmd_code = 0;
  logic [PW-1:0] cmd_part = 0;
  logic rd_valid = 0;
  logic [BW-1:0] rd_blk = 0;
  logic rd_new_blk = 0;
  logic [2:0] rd_src;
  logic prog_abort, sr_ready, sr_seq_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic last_abort;
  int em [NP];

  always #2.5 clk = ~clk;

  rwp_arbiter #(.NUM_PARTS(NP), .BLK_W(BW), .PROG_BUSY_CYCLES(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_part(cmd_part), .rd_valid(rd_valid), .rd_blk(rd_blk),
    .rd_new_blk(rd_new_blk), .rd_src(rd_src), .prog_abort(prog_abort),
    .sr_ready(sr_ready), .sr_seq_err(sr_seq_err)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cmd(logic [7:0] code, int p);
    @(negedge clk);
    cmd_valid = 1; cmd_code = code; cmd_part = PW'(p);
    @(negedge clk);
    cmd_valid = 0;
    last_abort = prog_abort;
  endtask

  task automatic rd(int p, int loc, bit nb, int exp, string tag);
    @(negedge clk);
    rd_valid = 1; rd_blk = {PW'(p), 4'(loc)}; rd_new_blk = nb;
    #1 chk(tag, rd_src, exp);
    @(posedge clk); #1;
    rd_valid = 0; rd_new_blk = 0;
  endtask

  function automatic int code_of(int k);
    case (k)
      0: return 8'hFF;
      1: return 8'h70;
      2: return 8'h90;
      default: return 8'h98;
    endcase
  endfunction

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready", sr_ready, 1);
    chk("R1 err", sr_seq_err, 0);
    chk("R1 abort", prog_abort, 0);
    chk("R2 idle none", rd_src, 4);
    for (int p = 0; p < NP; p++) begin
      em[p] = 0;
      rd(p, p, 0, 0, "R1 array");
    end

    for (int p = 0; p < NP; p++)
      for (int k = 0; k < 4; k++) begin
        cmd(8'(code_of(k)), p);
        em[p] = k;
        for (int q = 0; q < NP; q++) rd(q, q + k, 0, em[q], "R2 mode sweep");
      end
    for (int p = 0; p < NP; p++) cmd(8'hFF, p);

    cmd(8'h90, 1);
    cmd(8'hE8, 1);
    rd(1, 0, 0, 1, "R3 owner status");
    rd(0, 3, 0, 4, "R5 no new block");
    rd(0, 3, 1, 0, "R5 new block");
    rd(0, 3, 0, 0, "R5 latched block");
    rd(0, 5, 0, 4, "R5 other block");
    rd(2, 1, 0, 4, "R5 untouched part");
    cmd(8'h90, 1);
    rd(1, 0, 0, 1, "R10 owner cmd ignored");
    cmd(8'hE8, 2);
    rd(2, 1, 1, 0, "R10 second setup ignored");
    cmd(8'hFF, 3);
    chk("R7 no abort", last_abort, 0);
    chk("R7 no err", sr_seq_err, 0);
    rd(1, 0, 0, 1, "R7 program continues");
    cmd(8'h70, 2);
    rd(2, 1, 0, 1, "R11 status");
    cmd(8'h98, 3);
    rd(3, 1, 0, 3, "R11 query");
    cmd(8'h90, 3);
    rd(3, 1, 0, 2, "R11 id");
    cmd(8'hD0, 1);
    n = 0;
    while (!sr_ready && n < 100) begin n++; @(negedge clk); end
    chk("R4 busy length", n, PROG);
    chk("R4 no err", sr_seq_err, 0);
    rd(1, 0, 0, 1, "R4 stays status");
    rd(0, 9, 0, 0, "R5 idle array");
    cmd(8'hFF, 1);
    rd(1, 0, 0, 0, "R4 array after FF");

    cmd(8'hE8, 0);
    cmd(8'hD0, 0);
    chk("R4 busy started", sr_ready, 0);
    cmd(8'hFF, 2);
    chk("R6 abort pulse", last_abort, 1);
    chk("R6 err", sr_seq_err, 1);
    chk("R6 ready", sr_ready, 1);
    @(negedge clk);
    chk("R6 pulse single", prog_abort, 0);
    rd(2, 0, 0, 0, "R6 target array");
    rd(0, 0, 0, 1, "R6 owner status");
    rd(1, 7, 0, 0, "R6 program ended");
    cmd(8'h70, 1);
    cmd(8'hFF, 1);
    chk("R8 err sticky", sr_seq_err, 1);
    cmd(8'h50, 3);
    chk("R8 cleared", sr_seq_err, 0);
    cmd(8'hFF, 0);

    cmd(8'h80, 1);
    rd(1, 0, 0, 1, "R9 owner status");
    rd(0, 2, 1, 4, "R9 new block blocked");
    rd(2, 2, 0, 4, "R9 blocked");
    cmd(8'h70, 3);
    rd(3, 2, 0, 4, "R9 status part blocked");
    cmd(8'hD0, 1);
    n = 0;
    while (!sr_ready && n < 100) begin n++; @(negedge clk); end
    chk("R4 fast busy length", n, PROG);
    rd(0, 2, 0, 0, "R9 after completion");
    chk("R8 no err", sr_seq_err, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule